// File: doc/BRIEF.md
# DSP Host Byte-Sequenced Data Port

This block is the byte-wide host side of a small signal processor. An external host reaches two ports through one address select bit: a status port that reports the processor's handshake flags, and a data port that moves a 16-bit data register one byte at a time. A width-mode flag chooses between word transfers, taken as two byte accesses low byte first, and single-byte transfers. A byte-sequence flag tracks which half of the word is next. A request flag tells the host that the processor has work pending for it.

The processor side loads a full word into the data register with a one-cycle strobe, which also raises the request flag. It sets the width mode with its own strobe. A host that has read or written the last byte of a transfer drops the request flag. A debug read returns the byte a normal read would return but leaves both flags as they were. Host writes to the status port are discarded, and the block reports each one with a one-cycle pulse.

Top module: `dsp_host_port`

## Requirements
- R1: `host_sel` = 1 addresses the status port and `host_sel` = 0 addresses the data port, for both reads and writes.
- R2: A status-port read returns the byte {RQM, DRS, DRC, 5'b0}, with RQM in bit 7, DRS in bit 6 and DRC in bit 5. The read changes no flag and does not change the data register.
- R3: A status-port write leaves the data register and all flags unchanged. `host_wr_dropped` is 1 in the cycle after that write and 0 in every other cycle.
- R4: With DRC = 0 and DRS = 0, a data-port read returns data bits 7:0 and sets DRS. RQM is unchanged.
- R5: With DRC = 0 and DRS = 1, a data-port read returns data bits 15:8 and clears both DRS and RQM.
- R6: With DRC = 1, a data-port read returns data bits 7:0 and clears RQM. DRS is unchanged.
- R7: A read with `host_peek` = 1 returns the same byte as a normal read on either port, and DRS and RQM stay unchanged.
- R8: With DRC = 0, a data-port write stores into bits 7:0 and sets DRS when DRS = 0. When DRS = 1, it stores into bits 15:8 and clears DRS and RQM.
- R9: With DRC = 1, a data-port write stores into bits 7:0 and clears RQM. DRS is unchanged.
- R10: A `core_load` strobe loads `core_data` into the data register and sets RQM. If a host data access falls in the same cycle, that access still makes its DRS change. The loaded word and RQM = 1 override the host's byte store and its RQM clear.
- R11: Reset clears the data register, DRS, RQM, DRC and `host_rdata`.
- R12: `host_rdata` takes the read byte in the cycle after a read strobe and holds it otherwise. When read and write strobes arrive together, the cycle is handled as a read only.
- R13: A `core_mode_wr` strobe copies `core_mode8` into DRC (1 = byte mode) and leaves DRS unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Port select: 1 = status port, 0 = data port |
| host_rd | input | 1 | One-cycle host read strobe |
| host_wr | input | 1 | One-cycle host write strobe |
| host_peek | input | 1 | Marks a read as a debug read with no side effects |
| host_wdata | input | DATA_W/2 | Host write byte |
| host_rdata | output | DATA_W/2 | Registered host read byte |
| host_wr_dropped | output | 1 | Pulses 1 in the cycle after a discarded status-port write |
| core_load | input | 1 | Processor strobe that loads the data register and sets RQM |
| core_data | input | DATA_W | Word loaded by `core_load` |
| core_mode_wr | input | 1 | Processor strobe that updates the width mode |
| core_mode8 | input | 1 | New DRC value: 1 = byte mode, 0 = word mode |
| data_reg | output | DATA_W | Current data register |
| flag_rqm | output | 1 | Request flag |
| flag_drs | output | 1 | Byte-sequence flag |
| flag_drc | output | 1 | Width-mode flag |

## Verification
The hardest case to reach is a processor load that arrives in the same cycle as a host access. The outcome depends on DRS before the access and on the width mode, so every pairing has to come up. The sweep steps through both width modes, every access kind and both settings of the coincident load. It repeats each pattern enough times that the access meets DRS at 0 and at 1. A long pseudo-random run with a shift register follows. It mixes debug reads, collided strobes and mode changes that arrive partway through a word, and a bench model checks every cycle.

// File: rtl/dhp_pkg.sv
package dhp_pkg;

  typedef struct packed {
    logic rqm;
    logic drs;
    logic drc;
  } dhp_flags_t;

  // Flag effect of one side-effecting data-port transfer (read or write).
  function automatic dhp_flags_t flags_after_xfer(dhp_flags_t f);
    dhp_flags_t n;
    n = f;
    if (f.drc) begin
      n.rqm = 1'b0;
    end else if (f.drs) begin
      n.drs = 1'b0;
      n.rqm = 1'b0;
    end else begin
      n.drs = 1'b1;
    end
    return n;
  endfunction

  // The upper half of the word is next only in word mode with DRS set.
  function automatic logic upper_turn(dhp_flags_t f);
    return !f.drc && f.drs;
  endfunction

endpackage

// File: rtl/dhp_flags.sv
module dhp_flags
  import dhp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_ev,
  input  logic       core_load,
  input  logic       mode_wr,
  input  logic       mode8,
  output dhp_flags_t flags_q
);

  dhp_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (xfer_ev) flags_d = flags_after_xfer(flags_q);
    if (core_load) flags_d.rqm = 1'b1;
    if (mode_wr) flags_d.drc = mode8;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

endmodule

// File: rtl/dhp_datareg.sv
module dhp_datareg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ev,
  input  logic              upper,
  input  logic [DATA_W/2-1:0] wbyte,
  input  logic              core_load,
  input  logic [DATA_W-1:0] core_data,
  output logic [DATA_W-1:0] dr_q
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] merge_byte(
    logic [DATA_W-1:0] cur, logic hi, logic [BYTE_W-1:0] b);
    logic [DATA_W-1:0] r;
    r = cur;
    if (hi) r[DATA_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  logic [DATA_W-1:0] dr_d;

  always_comb begin
    dr_d = dr_q;
    if (wr_ev) dr_d = merge_byte(dr_q, upper, wbyte);
    if (core_load) dr_d = core_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dr_q <= '0;
    else        dr_q <= dr_d;
  end

endmodule

// File: rtl/dhp_rdport.sv
module dhp_rdport #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_ev,
  input  logic                sel_status,
  input  logic                upper,
  input  logic [DATA_W-1:0]   dr,
  input  logic [DATA_W/2-1:0] status_byte,
  output logic [DATA_W/2-1:0] rdata_q
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  function automatic logic [BYTE_W-1:0] pick_byte(logic [DATA_W-1:0] w, logic hi);
    return hi ? w[DATA_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_ev) rdata_q <= sel_status ? status_byte : pick_byte(dr, upper);
  end

endmodule

// File: rtl/dsp_host_port.sv
module dsp_host_port
  import dhp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_sel,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic                host_peek,
  input  logic [DATA_W/2-1:0] host_wdata,
  output logic [DATA_W/2-1:0] host_rdata,
  output logic                host_wr_dropped,
  input  logic                core_load,
  input  logic [DATA_W-1:0]   core_data,
  input  logic                core_mode_wr,
  input  logic                core_mode8,
  output logic [DATA_W-1:0]   data_reg,
  output logic                flag_rqm,
  output logic                flag_drs,
  output logic                flag_drc
);

  localparam int unsigned BYTE_W = DATA_W / 2;
  localparam int unsigned PAD_W  = BYTE_W - 3;

  dhp_flags_t flags;

  // Named decode events
  logic wr_ev;        // write that survives a colliding read (R12)
  logic data_xfer_ev; // data-port access with side effects (R4-R9)
  logic data_wr_ev;   // data-port byte store
  logic stat_wr_ev;   // discarded status write (R3)
  logic upper_ev;     // next byte is the upper half
  logic [BYTE_W-1:0] status_byte;

  assign wr_ev        = host_wr && !host_rd;
  assign data_wr_ev   = !host_sel && wr_ev;
  assign stat_wr_ev   = host_sel && wr_ev;
  assign data_xfer_ev = !host_sel && ((host_rd && !host_peek) || wr_ev);
  assign upper_ev     = upper_turn(flags);
  assign status_byte  = {flags.rqm, flags.drs, flags.drc, {PAD_W{1'b0}}};

  dhp_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_ev   (data_xfer_ev),
    .core_load (core_load),
    .mode_wr   (core_mode_wr),
    .mode8     (core_mode8),
    .flags_q   (flags)
  );

  dhp_datareg #(.DATA_W(DATA_W)) u_datareg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ev     (data_wr_ev),
    .upper     (upper_ev),
    .wbyte     (host_wdata),
    .core_load (core_load),
    .core_data (core_data),
    .dr_q      (data_reg)
  );

  dhp_rdport #(.DATA_W(DATA_W)) u_rdport (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_ev       (host_rd),
    .sel_status  (host_sel),
    .upper       (upper_ev),
    .dr          (data_reg),
    .status_byte (status_byte),
    .rdata_q     (host_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) host_wr_dropped <= 1'b0;
    else        host_wr_dropped <= stat_wr_ev;
  end

  assign flag_rqm = flags.rqm;
  assign flag_drs = flags.drs;
  assign flag_drc = flags.drc;

  // Assertions
  a_r2_status_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel && !core_load && !core_mode_wr) |=>
      ($stable(flag_rqm) && $stable(flag_drs) && $stable(flag_drc) && $stable(data_reg)));

  a_r3_status_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_rd && host_sel && !core_load) |=>
      (host_wr_dropped && $stable(data_reg) && $stable(flag_drs) && $stable(flag_rqm)));

  a_r4_low_read_sets_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_peek && !host_sel && !flag_drc && !flag_drs) |=> flag_drs);

  a_r5_high_read_ends_word: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_peek && !host_sel && !flag_drc && flag_drs && !core_load) |=>
      (!flag_drs && !flag_rqm));

  a_r6_byte_mode_keeps_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel && flag_drc && !core_mode_wr) |=> $stable(flag_drs));

  a_r7_peek_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_peek && !core_load) |=> ($stable(flag_rqm) && $stable(flag_drs)));

  a_r10_load_sets_request: assert property (@(posedge clk) disable iff (!rst_n)
    core_load |=> (flag_rqm && data_reg == $past(core_data)));

  a_r13_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    core_mode_wr |=> (flag_drc == $past(core_mode8)));

endmodule

// File: tb/test_dsp_host_port.sv
module test_dsp_host_port;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_rd, host_wr, host_peek;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        host_wr_dropped;
  logic        core_load;
  logic [15:0] core_data;
  logic        core_mode_wr, core_mode8;
  logic [15:0] data_reg;
  logic        flag_rqm, flag_drs, flag_drc;

  always #10 clk = ~clk; // 50 MHz

  dsp_host_port #(.DATA_W(16)) i_dsp_host_port (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_rd(host_rd), .host_wr(host_wr), .host_peek(host_peek),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_wr_dropped(host_wr_dropped),
    .core_load(core_load), .core_data(core_data),
    .core_mode_wr(core_mode_wr), .core_mode8(core_mode8),
    .data_reg(data_reg), .flag_rqm(flag_rqm), .flag_drs(flag_drs), .flag_drc(flag_drc)
  );

  int vectors = 0;
  int fails   = 0;

  // Bench model state
  logic [15:0] m_dr;
  logic        m_drs, m_rqm, m_drc, m_drop;
  logic [7:0]  m_rd;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    host_sel = 0; host_rd = 0; host_wr = 0; host_peek = 0; host_wdata = '0;
    core_load = 0; core_data = '0; core_mode_wr = 0; core_mode8 = 0;
  endtask

  task automatic compare_all(input string tr, input string tf);
    chk(tr, "host_rdata", 32'(host_rdata), 32'(m_rd));
    chk(tf, "data_reg",   32'(data_reg),   32'(m_dr));
    chk(tf, "drs",        32'(flag_drs),   32'(m_drs));
    chk(tf, "rqm",        32'(flag_rqm),   32'(m_rqm));
    chk(tf, "drc",        32'(flag_drc),   32'(m_drc));
    chk("R3", "wr_dropped", 32'(host_wr_dropped), 32'(m_drop));
  endtask

  // One cycle: drive at a falling edge, sample at the next falling edge.
  task automatic step(input logic sel, input logic rd, input logic wr, input logic pk,
                      input logic [7:0] wd, input logic ld, input logic [15:0] lv,
                      input logic mw, input logic m8);
    logic [15:0] n_dr;
    logic        n_drs, n_rqm, n_drc, wr_only, touch, second;
    string       tr, tf;
    host_sel = sel; host_rd = rd; host_wr = wr; host_peek = pk; host_wdata = wd;
    core_load = ld; core_data = lv; core_mode_wr = mw; core_mode8 = m8;

    second  = (m_drc == 1'b0) && (m_drs == 1'b1);
    wr_only = wr && !rd;
    touch   = !sel && ((rd && !pk) || wr_only);
    n_dr = m_dr; n_drs = m_drs; n_rqm = m_rqm; n_drc = m_drc;

    if (rd) m_rd = sel ? {m_rqm, m_drs, m_drc, 5'b00000}
                       : (second ? m_dr[15:8] : m_dr[7:0]);
    if (touch) begin
      if (m_drc)       n_rqm = 1'b0;
      else if (second) begin n_drs = 1'b0; n_rqm = 1'b0; end
      else             n_drs = 1'b1;
    end
    if (wr_only && !sel) begin
      if (second) n_dr = {wd, m_dr[7:0]};
      else        n_dr = {m_dr[15:8], wd};
    end
    if (ld) begin n_dr = lv; n_rqm = 1'b1; end
    if (mw) n_drc = m8;

    if (rd && sel)       tr = "R2";
    else if (rd && pk)   tr = "R7";
    else if (rd && m_drc) tr = "R6";
    else if (rd && second) tr = "R5";
    else if (rd)         tr = "R4";
    else                 tr = "R12";

    if (rd && wr)        tf = "R12";
    else if (ld)         tf = "R10";
    else if (mw)         tf = "R13";
    else if (sel && wr)  tf = "R3";
    else if (sel)        tf = "R2";
    else if (rd && pk)   tf = "R7";
    else if (wr)         tf = m_drc ? "R9" : "R8";
    else if (rd)         tf = m_drc ? "R6" : (second ? "R5" : "R4");
    else                 tf = "R12";

    m_drop = wr_only && sel;

    @(negedge clk);
    m_dr = n_dr; m_drs = n_drs; m_rqm = n_rqm; m_drc = n_drc;
    compare_all(tr, tf);
    idle();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_dr = '0; m_drs = 0; m_rqm = 0; m_drc = 0; m_rd = '0; m_drop = 0;
    // R11: reset values
    chk("R11", "data_reg", 32'(data_reg), 0);
    chk("R11", "flags", 32'({flag_rqm, flag_drs, flag_drc}), 0);
    chk("R11", "host_rdata", 32'(host_rdata), 0);

    // R1: status vs data port selection, word mode
    step(0, 0, 0, 0, 8'h00, 1, 16'hA5C3, 0, 0);
    step(0, 1, 0, 0, 8'h00, 0, 16'h0000, 0, 0);
    chk("R1", "data port low byte", 32'(host_rdata), 32'h00C3);
    step(1, 1, 0, 0, 8'h00, 0, 16'h0000, 0, 0);
    chk("R1", "status port byte", 32'(host_rdata), 32'h00C0);
    step(0, 1, 0, 0, 8'h00, 0, 16'h0000, 0, 0);
    chk("R1", "data port high byte", 32'(host_rdata), 32'h00A5);
    step(1, 0, 1, 0, 8'h5A, 0, 16'h0000, 0, 0);
    step(0, 0, 0, 0, 8'h00, 0, 16'h0000, 0, 0); // R3 pulse drops again

    // Sweep: both widths, every access kind, with and without coincident load
    for (int m = 0; m < 2; m++) begin
      step(0, 0, 0, 0, 8'h00, 0, 16'h0000, 1, logic'(m));
      for (int rep = 0; rep < 4; rep++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 4; k++)
            for (int l = 0; l < 2; l++) begin
              logic [7:0]  wd;
              logic [15:0] lv;
              wd = 8'(rep * 37 + s * 11 + k * 5 + l * 3 + m * 101);
              lv = 16'((rep + 1) * 4099 + k * 257 + s * 17 + m);
              step(logic'(s), logic'(k == 0 || k == 1 || k == 3), logic'(k == 2 || k == 3),
                   logic'(k == 1), wd, logic'(l), lv, 0, 0);
            end
    end

    // Pseudo-random mixing
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5], lfsr[1], lfsr[2] & lfsr[6], lfsr[3] & lfsr[7],
           lfsr[15:8], lfsr[4] & lfsr[9] & lfsr[11], {lfsr[7:0], lfsr[15:8]},
           lfsr[10] & lfsr[12] & lfsr[14], lfsr[13]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule